// File: doc/BRIEF.md
# Watchdog Supervisor with Reset Pulse Generator

This block supervises a processor through a single strobe input that the software must toggle regularly. Each rising or falling change of the strobe restarts a timeout counter. If the counter runs out before the next change arrives, the block raises its reset outputs for a fixed reset period and pulls a fault output low. The fault output stays low until the strobe changes again, so software that comes back up can tell a watchdog reset from a power reset.

All timing is counted in ticks of a clock-enable input, so one clock domain can drive time bases from microseconds to milliseconds. A timing-select input picks between a single long timeout and a short running timeout. With the short timeout, the first interval after every reset still uses the long value, which gives boot code time to start. A power-good input stands in for an external supply monitor. While it is low, reset is held, and the full reset period runs again once it returns. If the strobe stops for good, the block produces a repeating train of reset pulses, each separated by one long timeout.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high, `rst_out`=1, `rst_out_n`=0 and `wd_fault_n`=1. After `rst` falls, `rst_out` stays high for exactly RST_TICKS ticks, then falls.
- R2: `rst_out_n` is the complement of `rst_out` in every cycle after reset.
- R3: With `alt_timing`=0 and no strobe change, `rst_out` falls and rises again LONG_TICKS ticks later. Each watchdog reset pulse then lasts RST_TICKS ticks. The timeout counter is held at zero while `rst_out` is high.
- R4: A rising change and a falling change of `wd_strobe` both restart the timeout. The restart acts 3 clocks after the change: two synchronizer flops, then the edge is taken into the counter. A change applied just before clock k therefore moves the next expiry to LONG_TICKS+3 clocks after it when `alt_timing`=0, with one tick per clock.
- R5: With `alt_timing`=1, the first interval after any reset lasts LONG_TICKS ticks. After a strobe change, the interval lasts SHORT_TICKS ticks, so the expiry comes SHORT_TICKS+3 clocks after the change.
- R6: `wd_fault_n` falls in the same clock in which a watchdog expiry raises `rst_out`. It stays low through that reset pulse and through later expiries. It rises 3 clocks after the next change of `wd_strobe`.
- R7: If `wd_strobe` never changes, `rst_out` repeats as a pattern of LONG_TICKS ticks low and RST_TICKS ticks high. This holds for both values of `alt_timing`.
- R8: When `pwr_good`=0, `rst_out` is high at the next clock and stays high. When `pwr_good` returns to 1, `rst_out` stays high for RST_TICKS more ticks.
- R9: Time advances only in cycles with `tick_en`=1. With no ticks, a reset pulse never ends. With a tick every other clock, each period lasts about twice as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable, one tick per high cycle |
| alt_timing | input | 1 | 0: long timeout only; 1: short running timeout, long first interval |
| pwr_good | input | 1 | Supply-good indication, low forces reset |
| wd_strobe | input | 1 | Watchdog strobe from software, asynchronous |
| rst_out | output | 1 | Active-high reset output |
| rst_out_n | output | 1 | Active-low reset output |
| wd_fault_n | output | 1 | Low after a watchdog expiry until the next strobe change |

## Verification
The hardest state to reach is the short running timeout. It exists only after a reset has ended, the long first interval has started, and a strobe change has passed the synchronizer before that interval expires. The bench waits for the falling edge of reset, applies one change a few clocks later, and times the following expiry against SHORT_TICKS plus the three-clock restart latency. A second hard state is a fault flag that outlives a reset pulse and a second expiry. The stimulus reaches it by holding the strobe still across two full cycles before it applies the clearing change.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    TMODE_STD = 1'b0,
    TMODE_ALT = 1'b1
  } tmode_e;

  function automatic tmode_e tmode_from_pin(input logic pin);
    return pin ? TMODE_ALT : TMODE_STD;
  endfunction
endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_p
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] chain;

  // synchronizer stages plus one history flop for change detection
  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign edge_p = chain[LAST] ^ chain[STAGES];
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic pwr_good,
  input  logic expire,
  output logic rst_q,
  output logic rst_n_q
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] END_CNT = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good || expire) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
      cnt     <= '0;
    end else if (rst_q && tick_en) begin
      if (cnt == END_CNT) begin
        rst_q   <= 1'b0;
        rst_n_q <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_pg_forces_rst_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (rst_q && !rst_n_q));
  assert_expire_starts_rst_R3: assert property (@(posedge clk) disable iff (rst)
    expire |=> rst_q);
  assert_no_tick_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (rst_q && !tick_en) |=> rst_q);
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
  import wdog_pkg::*;
#(
  parameter int LONG_TICKS  = 1600,
  parameter int SHORT_TICKS = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_en,
  input  tmode_e tmode,
  input  logic   hold_clr,
  input  logic   kick,
  output logic   expire,
  output logic   fault_q
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          first_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = (tmode == TMODE_ALT && !first_q) ? SHORT_M1 : LONG_M1;
  assign expire = !hold_clr && !kick && tick_en && (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      first_q <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      if (hold_clr) begin
        cnt     <= '0;
        first_q <= 1'b1;
      end else if (kick) begin
        cnt     <= '0;
        first_q <= 1'b0;
      end else if (tick_en) begin
        cnt <= expire ? '0 : cnt + 1'b1;
      end
      if (kick)        fault_q <= 1'b0;
      else if (expire) fault_q <= 1'b1;
    end
  end

  assert_cnt_held_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    hold_clr |=> (cnt == '0));
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !kick) |=> fault_q);
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LONG_TICKS));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int RST_TICKS   = 200,
  parameter int LONG_TICKS  = 1600,
  parameter int SHORT_TICKS = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic alt_timing,
  input  logic pwr_good,
  input  logic wd_strobe,
  output logic rst_out,
  output logic rst_out_n,
  output logic wd_fault_n
);
  logic   kick;
  logic   expire;
  logic   fault_q;
  logic   rst_q;
  logic   rst_n_q;
  tmode_e tmode;

  assign tmode = tmode_from_pin(alt_timing);

  wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (wd_strobe),
    .edge_p (kick)
  );

  wdog_timeout #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .tmode    (tmode),
    .hold_clr (rst_q),
    .kick     (kick),
    .expire   (expire),
    .fault_q  (fault_q)
  );

  wdog_rst_pulse #(.RST_TICKS(RST_TICKS)) u_rpg (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .pwr_good (pwr_good),
    .expire   (expire),
    .rst_q    (rst_q),
    .rst_n_q  (rst_n_q)
  );

  assign rst_out    = rst_q;
  assign rst_out_n  = rst_n_q;
  assign wd_fault_n = ~fault_q;

  assert_rst_complement_R2: assert property (@(posedge clk) disable iff (rst)
    rst_out != rst_out_n);
  assert_fault_with_rst_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_fault_n) |-> rst_out);
endmodule

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;
  localparam int RT = 5;
  localparam int LT = 40;
  localparam int ST = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1;
  logic alt_timing = 1'b0;
  logic pwr_good = 1'b1;
  logic wd_strobe = 1'b0;
  logic rst_out, rst_out_n, wd_fault_n;
  logic [1:0] tick_mode = 2'd0; // 0 always, 1 never, 2 every other clock
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    case (tick_mode)
      2'd0:    tick_en <= 1'b1;
      2'd1:    tick_en <= 1'b0;
      default: tick_en <= ~tick_en;
    endcase
  end

  wdog_supervisor #(.RST_TICKS(RT), .LONG_TICKS(LT), .SHORT_TICKS(ST)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .alt_timing(alt_timing),
    .pwr_good(pwr_good), .wd_strobe(wd_strobe),
    .rst_out(rst_out), .rst_out_n(rst_out_n), .wd_fault_n(wd_fault_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_out == 1'b1 && n < 5000);
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_out == 1'b0 && n < 5000);
  endtask

  task automatic do_reset();
    int n;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_fall(n);
  endtask

  task automatic t_power_on();
    int n;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_out == 1'b1, "R1 rst_out in reset", rst_out, 1);
    chk(rst_out_n == 1'b0, "R2 rst_out_n in reset", rst_out_n, 0);
    chk(wd_fault_n == 1'b1, "R1 wd_fault_n in reset", wd_fault_n, 1);
    rst = 1'b0;
    wait_fall(n);
    chk(n == RT, "R1 power-on pulse length", n, RT);
    chk(rst_out_n == 1'b1, "R2 rst_out_n after pulse", rst_out_n, 1);
  endtask

  task automatic t_std_expire();
    int n;
    alt_timing = 1'b0;
    do_reset();
    wait_rise(n);
    chk(n == LT, "R3 long timeout", n, LT);
    chk(wd_fault_n == 1'b0, "R6 fault with expiry", wd_fault_n, 0);
    chk(rst_out_n == 1'b0, "R2 complement in pulse", rst_out_n, 0);
    wait_fall(n);
    chk(n == RT, "R3 watchdog pulse length", n, RT);
  endtask

  task automatic t_kick_edges();
    int n;
    alt_timing = 1'b0;
    do_reset();
    repeat (5) @(negedge clk);
    wd_strobe = 1'b1;
    wait_rise(n);
    chk(n == LT + 3, "R4 rising edge restart", n, LT + 3);
    wait_fall(n);
    repeat (5) @(negedge clk);
    wd_strobe = 1'b0;
    wait_rise(n);
    chk(n == LT + 3, "R4 falling edge restart", n, LT + 3);
  endtask

  task automatic t_fault_hold();
    int n;
    alt_timing = 1'b0;
    do_reset();
    wait_rise(n);
    chk(wd_fault_n == 1'b0, "R6 fault low at expiry", wd_fault_n, 0);
    wait_fall(n);
    chk(wd_fault_n == 1'b0, "R6 fault low after pulse", wd_fault_n, 0);
    wait_rise(n);
    wait_fall(n);
    chk(wd_fault_n == 1'b0, "R6 fault low after 2nd expiry", wd_fault_n, 0);
    wd_strobe = ~wd_strobe;
    repeat (2) @(negedge clk);
    chk(wd_fault_n == 1'b0, "R6 fault still low 2 clk after change", wd_fault_n, 0);
    @(negedge clk);
    chk(wd_fault_n == 1'b1, "R6 fault clears 3 clk after change", wd_fault_n, 1);
  endtask

  task automatic t_alt_mode();
    int n;
    alt_timing = 1'b1;
    do_reset();
    wait_rise(n);
    chk(n == LT, "R5 alt first interval long", n, LT);
    wait_fall(n);
    repeat (5) @(negedge clk);
    wd_strobe = ~wd_strobe;
    wait_rise(n);
    chk(n == ST + 3, "R5 alt short interval", n, ST + 3);
    wait_fall(n);
    chk(n == RT, "R7 alt pulse length", n, RT);
    wait_rise(n);
    chk(n == LT, "R7 alt stuck interval long", n, LT);
    wait_fall(n);
    wait_rise(n);
    chk(n == LT, "R7 alt repeat interval", n, LT);
    alt_timing = 1'b0;
  endtask

  task automatic t_stuck_std();
    int n;
    alt_timing = 1'b0;
    do_reset();
    for (int k = 0; k < 2; k++) begin
      wait_rise(n);
      chk(n == LT, "R7 std stuck low time", n, LT);
      wait_fall(n);
      chk(n == RT, "R7 std stuck high time", n, RT);
    end
  endtask

  task automatic t_power_good();
    int n;
    do_reset();
    repeat (5) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk(rst_out == 1'b1, "R8 pg low forces reset", rst_out, 1);
    chk(rst_out_n == 1'b0, "R8 pg low forces rst_out_n", rst_out_n, 0);
    repeat (10) @(negedge clk);
    chk(rst_out == 1'b1, "R8 reset held while pg low", rst_out, 1);
    pwr_good = 1'b1;
    wait_fall(n);
    chk(n == RT, "R8 pulse after pg return", n, RT);
  endtask

  task automatic t_tick_base();
    int n;
    tick_mode = 2'd1;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(rst_out == 1'b1, "R9 no tick keeps reset", rst_out, 1);
    tick_mode = 2'd2;
    wait_fall(n);
    chk(n >= 2*RT - 1 && n <= 2*RT, "R9 half-rate pulse", n, 2*RT);
    wait_rise(n);
    chk(n >= 2*LT - 1 && n <= 2*LT, "R9 half-rate timeout", n, 2*LT);
    tick_mode = 2'd0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_power_on();
    t_std_expire();
    t_kick_edges();
    t_fault_hold();
    t_alt_mode();
    t_stuck_std();
    t_power_good();
    t_tick_base();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule